// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

This block is a watchdog timer with a small register interface. Its control register accepts a new setting only through a two-step handshake. Software first writes a fixed unlock word. The next control write must then carry a second key byte in the same word as the configuration. That configuration holds an enable flag, a two-bit power field, a two-bit divider select and a 16-bit reload value. Each accepted handshake loads the down-counter from the reload field and restarts the prescaler. Software keeps the system alive by repeating the handshake before the count runs out.

A prescaler divides the clock by a power of two chosen by the divider select. The counter steps down on every divided tick, but only while the watchdog is enabled and the power field is fully on. When the count runs out, the block emits a one-cycle reset request and disarms itself. It also sets a sticky flag that survives a warm reset, so boot software can tell that the last reset came from the watchdog. Only the power-on reset clears that flag. A status register shows the enable state, the flag, the power and divider settings, and the live count.

Top module: `pwd_watchdog`

## Requirements
- R1: A control write (address 0x0) of exactly 0x00BE0000 arms the block. If the next control write has 0xDC in bits 23:16, it commits: bit 31 is enable, bits 27:26 are power, bits 25:24 are divider select, and bits 15:0 are the reload value.
- R2: A control write that does not directly follow the unlock word (counting control writes only) changes nothing. Every control write other than the unlock word leaves the block disarmed. A second word with a wrong key is ignored. Writes to other addresses neither arm nor disarm the block.
- R3: Each commit loads the counter with the reload value and restarts the prescaler from zero. Repeating the handshake with enable set therefore acts as the keepalive.
- R4: A commit with bit 31 clear stops the watchdog. The count then holds at the loaded value and no reset request is produced.
- R5: The count drops by one every 2^(6*sel) clocks, where sel is the divider select. This holds only while enable is 1 and power is 3. With any other power value the count and the prescaler hold.
- R6: Expiry is a divided tick that finds the count at 0 or 1. On expiry the count becomes 0, rst_req is high for exactly the next cycle, and enable clears. A commit in the same cycle wins over the tick.
- R7: Expiry sets a sticky flag, shown in status bit 30. sys_rst_n leaves the flag unchanged and clears everything else. por_n clears everything, including the flag.
- R8: A read of status (address 0x8) returns enable in bit 31, the flag in bit 30, power in bits 27:26, divider select in bits 25:24, and the count in bits 15:0. All other bits read 0. Reads of every other address return 0. Writes to status change nothing.
- R9: After reset, the status read is zero except for the flag, and rst_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| sys_rst_n | input | 1 | Warm reset, active low, asynchronous; keeps the sticky flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong armed bit shows up at the first attempted commit. A commit that should land leaves status unchanged, or one that should be ignored rewrites it, and the difference is visible in the very next cycle. A prescaler or counter fault shows as a wrong count field within one divided tick of the fault. It also moves the rst_req pulse off its expected cycle. A flag that is lost or set by mistake shows in status bit 30 straight after the warm or power-on reset that should keep or clear it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_W     = 32;
    localparam int RELOAD_W  = 16;
    localparam int SEL_W     = 2;
    localparam int DIV_STEP  = 6;
    localparam int PRE_W     = DIV_STEP * ((1 << SEL_W) - 1);
    localparam int KEY_LSB   = 16;
    localparam int EN_BIT    = 31;
    localparam int FLAG_BIT  = 30;
    localparam int PWR_LSB   = 26;
    localparam int SEL_LSB   = 24;

    localparam logic [REG_W-1:0] UNLOCK_WORD = 32'h00BE_0000;
    localparam logic [7:0]       COMMIT_KEY  = 8'hDC;

    typedef struct packed {
        logic             en;
        logic [1:0]       pwr;
        logic [SEL_W-1:0] sel;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int LOAD_W = RELOAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [REG_W-1:0]  wdata,
    input  logic              expire,
    output logic              commit,
    output logic [LOAD_W-1:0] load_val,
    output wdt_cfg_t          cfg
);
    typedef struct packed {
        logic     armed;
        wdt_cfg_t cfg;
    } unl_st_t;

    unl_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        commit   = wr_ctrl && st_q.armed && (wdata[KEY_LSB +: 8] == COMMIT_KEY);
        load_val = wdata[LOAD_W-1:0];
        if (wr_ctrl) begin
            st_d.armed = (wdata == UNLOCK_WORD);
        end
        if (commit) begin
            st_d.cfg.en  = wdata[EN_BIT];
            st_d.cfg.pwr = wdata[PWR_LSB +: 2];
            st_d.cfg.sel = wdata[SEL_LSB +: SEL_W];
        end else if (expire) begin
            st_d.cfg.en  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !expire) |=> $stable(cfg));
    p_expire_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !commit) |=> !cfg.en);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int P_W   = PRE_W,
    parameter int S_W   = SEL_W,
    parameter int STEP  = DIV_STEP
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           restart,
    input  logic [S_W-1:0] sel,
    output logic           tick
);
    typedef struct packed {
        logic [P_W-1:0] pre;
    } pre_st_t;

    pre_st_t        st_d, st_q;
    logic [P_W-1:0] limit;

    always_comb begin
        limit = {P_W{1'b1}} >> (P_W - STEP * int'(sel));
        tick  = run && (st_q.pre == limit);
        st_d  = st_q;
        if (restart)   st_d.pre = '0;
        else if (tick) st_d.pre = '0;
        else if (run)  st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_tick_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.pre == '0));
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(st_q.pre));
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.pre == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             commit,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire,
    output logic [CNT_W-1:0] count,
    output logic             rst_req,
    output logic             wd_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    flag_d, flag_q;
    logic    at_end;

    always_comb begin
        at_end = (st_q.cnt <= CNT_W'(1));
        expire = !commit && tick && at_end;
        st_d     = st_q;
        st_d.req = expire;
        if (commit)    st_d.cnt = load_val;
        else if (tick) st_d.cnt = at_end ? '0 : st_q.cnt - 1'b1;
        flag_d = flag_q | expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign count   = st_q.cnt;
    assign rst_req = st_q.req;
    assign wd_flag = flag_q;

    p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    p_req_sets_flag_r7: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> wd_flag);
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
        wd_flag |=> wd_flag);
    p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> (count <= $past(count)));
    p_req_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == '0));
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int LOAD_W   = RELOAD_W,
    parameter int CTRL_OFS = 0,
    parameter int STAT_OFS = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              rst_req
);
    logic              core_rst_n;
    logic              wr_ctrl, commit, expire, run, tick, wd_flag;
    logic [LOAD_W-1:0] load_val, count;
    wdt_cfg_t          cfg;

    assign core_rst_n = por_n & sys_rst_n;
    assign wr_ctrl    = wr_en && (addr == ADDR_W'(CTRL_OFS));
    assign run        = cfg.en && (cfg.pwr == 2'b11);

    wdt_unlock #(.LOAD_W(LOAD_W)) u_unlock (
        .clk(clk), .rst_n(core_rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
        .expire(expire), .commit(commit), .load_val(load_val), .cfg(cfg)
    );

    wdt_prescaler #(.P_W(PRE_W), .S_W(SEL_W), .STEP(DIV_STEP)) u_pre (
        .clk(clk), .rst_n(core_rst_n), .run(run), .restart(commit),
        .sel(cfg.sel), .tick(tick)
    );

    wdt_counter #(.CNT_W(LOAD_W)) u_cnt (
        .clk(clk), .rst_n(core_rst_n), .por_n(por_n), .commit(commit),
        .load_val(load_val), .tick(tick), .expire(expire), .count(count),
        .rst_req(rst_req), .wd_flag(wd_flag)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(STAT_OFS)) begin
            rdata                      = REG_W'(count);
            rdata[EN_BIT]              = cfg.en;
            rdata[FLAG_BIT]            = wd_flag;
            rdata[PWR_LSB +: 2]        = cfg.pwr;
            rdata[SEL_LSB +: SEL_W]    = cfg.sel;
        end
    end

    p_stopped_no_req_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
        (!cfg.en && !commit) |=> !rst_req);
    p_unpowered_hold_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
        (!run && !commit) |=> $stable(count));
endmodule

// File: tb/test_pwd_watchdog.sv
`timescale 1ns/1ps
module test_pwd_watchdog;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = 4'h8;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    always #2 clk = ~clk;

    pwd_watchdog i_pwd_watchdog (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    int    n_vec = 0, n_bad = 0, cyc = 0;
    string tag = "R9";
    bit    done = 0;

    // behavioural reference model
    int m_en, m_pwr, m_sel, m_cnt, m_pre, m_flag, m_arm, m_req;

    always @(posedge clk or negedge por_n or negedge sys_rst_n) begin
        if (!por_n) begin
            m_en = 0; m_pwr = 0; m_sel = 0; m_cnt = 0; m_pre = 0;
            m_arm = 0; m_req = 0; m_flag = 0;
        end else if (!sys_rst_n) begin
            m_en = 0; m_pwr = 0; m_sel = 0; m_cnt = 0; m_pre = 0;
            m_arm = 0; m_req = 0;
        end else begin
            bit cmt, run, tk, ex;
            int lim;
            cmt = wr_en && addr == 4'h0 && m_arm != 0 && wdata[23:16] == 8'hDC;
            run = m_en != 0 && m_pwr == 3;
            lim = (1 << (6 * m_sel)) - 1;
            tk  = run && m_pre == lim;
            ex  = !cmt && tk && m_cnt <= 1;
            m_req = ex;
            if (cmt) begin
                m_en = wdata[31]; m_pwr = wdata[27:26]; m_sel = wdata[25:24];
                m_cnt = wdata[15:0]; m_pre = 0;
            end else begin
                if (run) m_pre = tk ? 0 : m_pre + 1;
                if (tk) m_cnt = (m_cnt <= 1) ? 0 : m_cnt - 1;
                if (ex) m_en = 0;
            end
            if (wr_en && addr == 4'h0) m_arm = (wdata == 32'h00BE0000);
            if (ex) m_flag = 1;
        end
    end

    function automatic logic [31:0] exp_rd();
        logic [31:0] v = '0;
        if (addr == 4'h8) begin
            v[31] = m_en[0]; v[30] = m_flag[0];
            v[27:26] = m_pwr[1:0]; v[25:24] = m_sel[1:0]; v[15:0] = m_cnt[15:0];
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if (rdata !== exp_rd() || rst_req !== m_req[0]) begin
                n_bad++;
                $display("FAIL %s cyc=%0d rdata=%h rst_req=%b expected rdata=%h rst_req=%0d",
                         tag, cyc, rdata, rst_req, exp_rd(), m_req);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired in %s actual=hung expected=finished", tag);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 4'h8; wdata = '0;
    endtask

    task automatic seq(input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = 4'h0; wdata = 32'h00BE0000;
        @(posedge clk); #1;
        wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 4'h8; wdata = '0;
    endtask

    task automatic rd_at(input logic [3:0] a, input int n);
        @(posedge clk); #1; addr = a;
        idle(n);
        #1; addr = 4'h8;
    endtask

    initial begin
        idle(3); #1;
        por_n = 1'b1; sys_rst_n = 1'b1;
        tag = "R9"; idle(3);
        tag = "R1"; seq(32'h8CDC_000A); idle(5);
        tag = "R3"; seq(32'h8CDC_000A); idle(5);
        seq(32'h8CDC_000A); idle(3);
        tag = "R6"; idle(15);
        tag = "R7"; @(posedge clk); #1; sys_rst_n = 1'b0; idle(2); #1; sys_rst_n = 1'b1;
        idle(3);
        tag = "R2";
        wr(4'h0, 32'h8CDC_0005); idle(2);
        wr(4'h0, 32'h00BE0000); wr(4'h0, 32'h1234_5678); wr(4'h0, 32'h8CDC_0005); idle(2);
        wr(4'h0, 32'h00BE0000); wr(4'h0, 32'h8CAB_0005); wr(4'h0, 32'h8CDC_0005); idle(2);
        wr(4'h0, 32'h00BE0000); wr(4'h8, 32'hFFFF_FFFF); wr(4'h0, 32'h8CDC_0030); idle(4);
        tag = "R4"; seq(32'h00DC_0007); idle(12);
        tag = "R5"; seq(32'h84DC_0005); idle(10);
        seq(32'h8DDC_0003); idle(250);
        seq(32'h8EDC_0002); idle(8300);
        tag = "R8"; seq(32'h8CDC_0040); wr(4'h8, 32'h0000_0000); idle(3);
        rd_at(4'h0, 3); rd_at(4'h4, 3); rd_at(4'hC, 3);
        tag = "R7"; @(posedge clk); #1; por_n = 1'b0; idle(2); #1; por_n = 1'b1;
        tag = "R9"; idle(4);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule